// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers up to 32 interrupt sources and presents one active-low request line, `nirq_n`, to a processor. Each source has a mode word and a vector word. The mode word holds a trigger type and a 3-bit priority. The vector word holds a 32-bit value that software reads back when it services that source. Software turns sources on and off through command words, where each 1 bit acts on one source and each 0 bit is ignored. It also clears latched edges through a separate command word.

Servicing works through one register. A read of the vector register returns the vector of the best pending, enabled source. The same read records that source as current and pushes its priority and number onto an 8-level nesting stack. From then on, `nirq_n` goes low again only for a source of strictly higher priority. A write of any value to the end-of-interrupt register pops one level. When nothing may be serviced, the vector read returns a programmable spurious value, and the status register then reads 0.

The bus is a single-cycle, word-addressed read/write port. Writes take effect at the clock edge. Read data is combinational from the current state, and the side effects of a vector read are applied at the edge that ends the read.

Top module: `pic_top`

## Requirements
- R1: A write to 0x84 enables each source whose data bit is 1. A write to 0x85 disables each source whose data bit is 1. Bits written as 0 change nothing. The enabled set reads back at 0x83 (bit i = source i).
- R2: The mode word of source i is at 0x00+i, with priority in bits [2:0] and trigger type in bits [5:4]. The type encodings are 0 = high level, 1 = rising edge, 2 = low level, 3 = falling edge. Types 2 and 3 are kept only for source 0 and for the external sources, which by default are sources 4 to 7. For any other source, bit 5 is stored as 0, so low level becomes high level and falling becomes rising.
- R3: For a level type, the source's bit in the raw pending register (0x82) follows the input, inverted for the low-level type, whether or not the source is enabled.
- R4: For an edge type, the selected edge sets the raw pending bit and the opposite edge does not. The bit stays set until a 1 is written to that bit of the clear command (0x86), or until a vector read services that source.
- R5: Among pending, enabled sources, the highest priority wins, with 7 the highest. Ties go to the lowest source number. A vector read at 0x80 that services a source returns that source's vector word, which is held at 0x40+i.
- R6: `nirq_n` is low exactly when some pending, enabled source has a priority strictly above the top of the nesting stack, or when the stack is empty and any pending, enabled source exists. A servicing vector read pushes one level onto the stack.
- R7: A vector read while `nirq_n` is high returns the spurious register (0x88, read/write) and changes nothing on the stack.
- R8: The status register (0x81) reads the number of the source on top of the stack. It reads 0 when the stack is empty or when the last vector read was spurious.
- R9: A write of any value to 0x87 pops one level, and a write with the stack empty does nothing. The stack never holds more than 8 levels, so eight such writes always empty it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Interrupt source inputs, synchronous to clk |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high and bus_wr is low |
| nirq_n | output | 1 | Active-low interrupt request |

## Verification
The bench first sweeps every source alone as a rising-edge source, each with a distinct priority and vector. This sweep shows whether a vector, status or auto-clear is routed to the wrong source number.

Arbitration is then tried with many mixed level patterns and arithmetically spread priorities that contain ties. The expected winner is computed in the bench, which separates priority ordering from index ordering. One pattern has no active input and must produce the spurious vector.

A climb through all eight priority levels, followed by eight end-of-interrupt writes, tells a correct strict-higher rule and a correct unwind from an off-by-one stack. The sweep of type writes over every source shows the per-source forcing of the negative-polarity types.

// File: rtl/pic_pkg.sv
// Package: shared encodings and address map of the nested priority
// interrupt controller. Assumes an 8-bit word address split into a
// 2-bit region and a 6-bit offset.
package pic_pkg;

    typedef enum logic [1:0] {
        TRIG_LVL_HI   = 2'd0,
        TRIG_EDGE_RISE = 2'd1,
        TRIG_LVL_LO   = 2'd2,
        TRIG_EDGE_FALL = 2'd3
    } trig_e;

    localparam logic [1:0] RGN_MODE = 2'b00;
    localparam logic [1:0] RGN_VEC  = 2'b01;
    localparam logic [1:0] RGN_CTRL = 2'b10;

    localparam logic [5:0] OFS_VECTOR = 6'h00;
    localparam logic [5:0] OFS_STATUS = 6'h01;
    localparam logic [5:0] OFS_RAW    = 6'h02;
    localparam logic [5:0] OFS_MASK   = 6'h03;
    localparam logic [5:0] OFS_EN     = 6'h04;
    localparam logic [5:0] OFS_DIS    = 6'h05;
    localparam logic [5:0] OFS_CLR    = 6'h06;
    localparam logic [5:0] OFS_EOI    = 6'h07;
    localparam logic [5:0] OFS_SPUR   = 6'h08;

    localparam logic [7:0] ADDR_VECTOR = {RGN_CTRL, OFS_VECTOR};
    localparam logic [7:0] ADDR_EN     = {RGN_CTRL, OFS_EN};
    localparam logic [7:0] ADDR_DIS    = {RGN_CTRL, OFS_DIS};
    localparam logic [7:0] ADDR_EOI    = {RGN_CTRL, OFS_EOI};

endpackage

// File: rtl/pic_src_cond.sv
// Source conditioning: turns each raw input into a pending bit according
// to its trigger type. Level types follow the input directly; edge types
// latch the chosen edge until a clear strobe. Assumes src_in is already
// synchronous to clk.
module pic_src_cond #(
    parameter int NUM_SRC = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_in,
    input  logic [NUM_SRC-1:0][1:0]  trig,
    input  logic [NUM_SRC-1:0]       clr,
    output logic [NUM_SRC-1:0]       pend
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic prev_q;
        logic edge_q;
        logic is_edge;
        logic neg_pol;
        logic hit;

        assign is_edge = trig[g][0];
        assign neg_pol = trig[g][1];
        assign hit     = neg_pol ? (prev_q & ~src_in[g]) : (src_in[g] & ~prev_q);

        // Purpose: remember the previous input sample for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= src_in[g];
        end

        // Purpose: latch a detected edge until cleared; idle in level modes.
        always_ff @(posedge clk) begin
            if (!rst_n)       edge_q <= 1'b0;
            else if (is_edge) edge_q <= (edge_q & ~clr[g]) | hit;
            else              edge_q <= 1'b0;
        end

        assign pend[g] = is_edge ? edge_q : (src_in[g] ^ neg_pol);
    end

endmodule

// File: rtl/pic_prio_arb.sv
// Priority arbiter: picks the candidate with the highest priority, the
// lowest index winning ties. Purely combinational; assumes NUM_SRC >= 2.
module pic_prio_arb #(
    parameter int NUM_SRC = 32,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]              cand,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio,
    output logic                            found,
    output logic [ID_W-1:0]                 win_id,
    output logic [PRIO_W-1:0]               win_prio
);

    // Purpose: linear scan; strict greater-than keeps the lowest index on ties.
    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_prio = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand[i] && (!found || prio[i] > win_prio)) begin
                found    = 1'b1;
                win_id   = ID_W'(i);
                win_prio = prio[i];
            end
        end
    end

endmodule

// File: rtl/pic_nest_stack.sv
// Nesting stack: holds the priority and number of each interrupt under
// service. Push and pop never arrive together (they come from distinct
// bus accesses). A push on a full stack and a pop on an empty one are
// dropped.
module pic_nest_stack #(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 5,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic [ID_W-1:0]   push_id,
    output logic              empty,
    output logic [PRIO_W-1:0] top_prio,
    output logic [ID_W-1:0]   top_id,
    output logic [CNT_W-1:0]  depth
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PRIO_W-1:0] prio_mem [DEPTH];
    logic [ID_W-1:0]   id_mem   [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  top_idx;

    assign wr_idx  = IDX_W'(cnt_q);
    assign top_idx = IDX_W'(cnt_q - 1'b1);

    // Purpose: maintain the level count and store pushed entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                prio_mem[i] <= '0;
                id_mem[i]   <= '0;
            end
        end else if (push && cnt_q < CNT_W'(DEPTH)) begin
            prio_mem[wr_idx] <= push_prio;
            id_mem[wr_idx]   <= push_id;
            cnt_q            <= cnt_q + 1'b1;
        end else if (pop && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign empty    = (cnt_q == '0);
    assign top_prio = empty ? '0 : prio_mem[top_idx];
    assign top_id   = empty ? '0 : id_mem[top_idx];
    assign depth    = cnt_q;

endmodule

// File: rtl/pic_top.sv
// Nested priority interrupt controller top: bus decode, per-source mode
// and vector words, enable set, spurious word and status logic, with
// source conditioning, arbitration and nesting in submodules.
// Assumes 2 <= NUM_SRC <= 32, PRIO_W <= 4, and a single-cycle bus whose
// read side effects are applied at the edge ending the read.
module pic_top
    import pic_pkg::*;
#(
    parameter int          NUM_SRC      = 32,
    parameter int          PRIO_W       = 3,
    parameter int          NEST_DEPTH   = 8,
    parameter logic [31:0] EXT_SRC_MASK = 32'h0000_00F0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               nirq_n
);

    localparam int ID_W  = $clog2(NUM_SRC);
    localparam int CNT_W = $clog2(NEST_DEPTH + 1);

    logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
    logic [NUM_SRC-1:0][1:0]        trig_q;
    logic [NUM_SRC-1:0][31:0]       vec_q;
    logic [NUM_SRC-1:0]             en_q;
    logic [NUM_SRC-1:0]             pend;
    logic [NUM_SRC-1:0]             cand;
    logic [NUM_SRC-1:0]             clr_bits;
    logic [NUM_SRC-1:0]             served;
    logic [31:0]                    spur_q;
    logic                           spur_flag_q;

    logic [1:0]      region;
    logic [5:0]      ofs;
    logic [ID_W-1:0] idx;
    logic            in_range;
    logic            wr_en;
    logic            rd_en;
    logic            mode_wr;
    logic            vec_wr;
    logic            ctrl_wr;
    logic            vec_rd;
    logic            eoi_wr;

    logic              found;
    logic [ID_W-1:0]   win_id;
    logic [PRIO_W-1:0] win_prio;
    logic              eligible;
    logic              take;
    logic              stk_empty;
    logic [PRIO_W-1:0] top_prio;
    logic [ID_W-1:0]   top_id;
    logic [CNT_W-1:0]  stk_depth;
    logic [ID_W-1:0]   status_id;

    // Address decode.
    assign region   = bus_addr[7:6];
    assign ofs      = bus_addr[5:0];
    assign idx      = bus_addr[ID_W-1:0];
    assign in_range = int'(ofs) < NUM_SRC;
    assign wr_en    = bus_sel & bus_wr;
    assign rd_en    = bus_sel & ~bus_wr;
    assign mode_wr  = wr_en & (region == RGN_MODE) & in_range;
    assign vec_wr   = wr_en & (region == RGN_VEC) & in_range;
    assign ctrl_wr  = wr_en & (region == RGN_CTRL);
    assign vec_rd   = rd_en & (region == RGN_CTRL) & (ofs == OFS_VECTOR);
    assign eoi_wr   = ctrl_wr & (ofs == OFS_EOI);

    // Purpose: per-source mode words, forcing internal polarity where required.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            trig_q <= '0;
        end else if (mode_wr) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (idx == ID_W'(i)) begin
                    prio_q[i] <= bus_wdata[PRIO_W-1:0];
                    if (i == 0 || EXT_SRC_MASK[i])
                        trig_q[i] <= bus_wdata[5:4];
                    else
                        trig_q[i] <= {1'b0, bus_wdata[4]};
                end
            end
        end
    end

    // Purpose: per-source vector words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (vec_wr) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (idx == ID_W'(i)) vec_q[i] <= bus_wdata;
            end
        end
    end

    // Purpose: enable set, updated by write-one enable and disable commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (ctrl_wr && ofs == OFS_EN) begin
            en_q <= en_q | bus_wdata[NUM_SRC-1:0];
        end else if (ctrl_wr && ofs == OFS_DIS) begin
            en_q <= en_q & ~bus_wdata[NUM_SRC-1:0];
        end
    end

    // Purpose: programmable spurious vector word.
    always_ff @(posedge clk) begin
        if (!rst_n)                         spur_q <= '0;
        else if (ctrl_wr && ofs == OFS_SPUR) spur_q <= bus_wdata;
    end

    // Purpose: remember whether the last vector read was spurious.
    always_ff @(posedge clk) begin
        if (!rst_n)      spur_flag_q <= 1'b0;
        else if (vec_rd) spur_flag_q <= ~take;
        else if (eoi_wr) spur_flag_q <= 1'b0;
    end

    // Edge clears come from the clear command and from servicing.
    assign served   = take ? (NUM_SRC'(1) << win_id) : '0;
    assign clr_bits = served |
                      ((ctrl_wr && ofs == OFS_CLR) ? bus_wdata[NUM_SRC-1:0] : '0);

    pic_src_cond #(
        .NUM_SRC (NUM_SRC)
    ) u_src (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_in (src_in),
        .trig   (trig_q),
        .clr    (clr_bits),
        .pend   (pend)
    );

    assign cand = pend & en_q;

    pic_prio_arb #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .ID_W    (ID_W)
    ) u_arb (
        .cand     (cand),
        .prio     (prio_q),
        .found    (found),
        .win_id   (win_id),
        .win_prio (win_prio)
    );

    assign eligible = found & (stk_empty | (win_prio > top_prio));
    assign take     = vec_rd & eligible;
    assign nirq_n   = ~eligible;

    pic_nest_stack #(
        .DEPTH  (NEST_DEPTH),
        .PRIO_W (PRIO_W),
        .ID_W   (ID_W),
        .CNT_W  (CNT_W)
    ) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take),
        .pop       (eoi_wr),
        .push_prio (win_prio),
        .push_id   (win_id),
        .empty     (stk_empty),
        .top_prio  (top_prio),
        .top_id    (top_id),
        .depth     (stk_depth)
    );

    assign status_id = (stk_empty || spur_flag_q) ? '0 : top_id;

    // Purpose: read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (region)
                RGN_MODE: if (in_range) begin
                    bus_rdata[PRIO_W-1:0] = prio_q[idx];
                    bus_rdata[5:4]        = trig_q[idx];
                end
                RGN_VEC: if (in_range) bus_rdata = vec_q[idx];
                RGN_CTRL: begin
                    case (ofs)
                        OFS_VECTOR: bus_rdata = eligible ? vec_q[win_id] : spur_q;
                        OFS_STATUS: bus_rdata = 32'(status_id);
                        OFS_RAW:    bus_rdata = 32'(pend);
                        OFS_MASK:   bus_rdata = 32'(en_q);
                        OFS_SPUR:   bus_rdata = spur_q;
                        default:    bus_rdata = '0;
                    endcase
                end
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pic_checker.sv
// Checker for pic_top: temporal properties on the command, stacking and
// request behaviour. Bound into every pic_top instance below.
module pic_checker
    import pic_pkg::*;
#(
    parameter int NUM_SRC    = 32,
    parameter int NEST_DEPTH = 8,
    parameter int ID_W       = $clog2(NUM_SRC),
    parameter int CNT_W      = $clog2(NEST_DEPTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [7:0]         bus_addr,
    input logic [31:0]        bus_wdata,
    input logic               nirq_n,
    input logic [NUM_SRC-1:0] mask,
    input logic [CNT_W-1:0]   depth,
    input logic [ID_W-1:0]    status_id
);

    logic vec_rd;
    logic eoi_wr;
    logic en_wr;
    logic dis_wr;

    assign vec_rd = bus_sel & ~bus_wr & (bus_addr == ADDR_VECTOR);
    assign eoi_wr = bus_sel & bus_wr & (bus_addr == ADDR_EOI);
    assign en_wr  = bus_sel & bus_wr & (bus_addr == ADDR_EN);
    assign dis_wr = bus_sel & bus_wr & (bus_addr == ADDR_DIS);

    assert_enable_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> ((mask & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

    assert_disable_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dis_wr |=> ((mask & $past(bus_wdata[NUM_SRC-1:0])) == '0));

    assert_quiet_when_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> nirq_n);

    assert_push_on_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !nirq_n) |=> (depth == $past(depth) + 1'b1));

    assert_spurious_no_push_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && nirq_n) |=> (depth == $past(depth)));

    assert_status_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == '0) |-> (status_id == '0));

    assert_eoi_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && depth != '0) |=> (depth == $past(depth) - 1'b1));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= CNT_W'(NEST_DEPTH));

endmodule

bind pic_top pic_checker #(
    .NUM_SRC    (NUM_SRC),
    .NEST_DEPTH (NEST_DEPTH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .nirq_n    (nirq_n),
    .mask      (en_q),
    .depth     (stk_depth),
    .status_id (status_id)
);

// File: tb/pic_top_tb.sv
`timescale 1ns/1ps
// Bench for pic_top: sweeps over sources, types, priority patterns and
// nesting depth; expected values computed from the requirements.
module pic_top_tb;

    localparam int N = 32;
    localparam logic [7:0] A_VEC  = 8'h80;
    localparam logic [7:0] A_STAT = 8'h81;
    localparam logic [7:0] A_RAW  = 8'h82;
    localparam logic [7:0] A_MASK = 8'h83;
    localparam logic [7:0] A_EN   = 8'h84;
    localparam logic [7:0] A_DIS  = 8'h85;
    localparam logic [7:0] A_CLR  = 8'h86;
    localparam logic [7:0] A_EOI  = 8'h87;
    localparam logic [7:0] A_SPUR = 8'h88;
    localparam logic [31:0] EXT   = 32'h0000_00F0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] src_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        nirq_n;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pic_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .nirq_n    (nirq_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
        #2;
    endtask

    task automatic set_src(input logic [N-1:0] v);
        @(negedge clk);
        src_in = v;
    endtask

    function automatic logic [31:0] bit1(input int i);
        return 32'h1 << i;
    endfunction

    initial begin
        #(20 * 200000);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] x;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        settle();
        chk("R6 reset nirq_n", 32'(nirq_n), 32'd1);
        rd(A_MASK, d); chk("R1 reset mask", d, 32'h0);
        rd(A_RAW, d);  chk("R3 reset raw", d, 32'h0);
        rd(A_STAT, d); chk("R8 reset status", d, 32'h0);

        // R7: spurious vector with nothing pending, and with a disabled pending source
        wr(A_SPUR, 32'hDEAD_BEEF);
        rd(A_SPUR, d); chk("R7 spurious readback", d, 32'hDEAD_BEEF);
        rd(A_VEC, d);  chk("R7 spurious vector", d, 32'hDEAD_BEEF);
        rd(A_STAT, d); chk("R7 status after spurious", d, 32'h0);
        set_src(bit1(3));
        settle();
        rd(A_VEC, d);  chk("R7 disabled source gives spurious", d, 32'hDEAD_BEEF);
        set_src('0);

        // R2: type/priority sweep over every source and type
        for (int i = 0; i < N; i++) begin
            for (int t = 0; t < 4; t++) begin
                logic [1:0] et;
                et = (i == 0 || EXT[i]) ? 2'(t) : {1'b0, 1'(t & 1)};
                wr(8'(i), (32'(t) << 4) | 32'(i % 8));
                rd(8'(i), d);
                chk($sformatf("R2 mode src %0d type %0d", i, t), d, (32'(et) << 4) | 32'(i % 8));
            end
            wr(8'(i), 32'h0);
        end

        // R1: write-one enable and disable commands
        wr(A_EN, 32'hA5A5_0F0F);
        rd(A_MASK, d); chk("R1 enable", d, 32'hA5A5_0F0F);
        wr(A_EN, 32'h0);
        rd(A_MASK, d); chk("R1 zero enable ignored", d, 32'hA5A5_0F0F);
        wr(A_DIS, 32'h0000_0F00);
        rd(A_MASK, d); chk("R1 disable", d, 32'hA5A5_000F);
        wr(A_DIS, 32'hFFFF_FFFF);
        rd(A_MASK, d); chk("R1 disable all", d, 32'h0);

        // R3: level types follow the input
        foreach (x[k]) begin end
        for (int p = 0; p < 4; p++) begin
            logic [31:0] pat;
            pat = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'h0 :
                  (p == 2) ? 32'h1234_5678 : 32'hA5A5_5A5A;
            set_src(pat);
            rd(A_RAW, d); chk("R3 level-high raw", d, pat);
        end
        wr(8'd4, 32'h20);
        wr(8'd9, 32'h20);
        rd(8'd9, d); chk("R2 internal low forced high", d, 32'h0);
        set_src(32'h0000_0210);
        rd(A_RAW, d); chk("R3 low-level ext src4, forced src9", d, 32'h0000_0200);
        set_src(32'h0);
        rd(A_RAW, d); chk("R3 low-level ext idle", d, 32'h0000_0010);
        wr(8'd4, 32'h0);
        wr(8'd9, 32'h0);

        // R4/R5/R6/R8/R9: each source alone as rising edge
        for (int i = 0; i < N; i++) begin
            wr(8'(i), 32'h10 | 32'(i % 8));
            wr(8'(8'h40 + i), 32'h1000 + 32'(i));
            wr(A_EN, bit1(i));
            settle();
            chk($sformatf("R6 idle src %0d", i), 32'(nirq_n), 32'd1);
            set_src(bit1(i));
            set_src('0);
            rd(A_RAW, d); chk($sformatf("R4 rising latched src %0d", i), d, bit1(i));
            chk($sformatf("R6 request src %0d", i), 32'(nirq_n), 32'd0);
            rd(A_VEC, d); chk($sformatf("R5 vector src %0d", i), d, 32'h1000 + 32'(i));
            rd(A_STAT, d); chk($sformatf("R8 status src %0d", i), d, 32'(i));
            rd(A_RAW, d); chk($sformatf("R4 auto clear src %0d", i), d, 32'h0);
            chk($sformatf("R6 released src %0d", i), 32'(nirq_n), 32'd1);
            wr(A_EOI, 32'(i * 7));
            rd(A_STAT, d); chk($sformatf("R9 eoi status src %0d", i), d, 32'h0);
            wr(A_DIS, bit1(i));
            wr(8'(i), 32'h0);
        end

        // R4: clear command and falling edge
        wr(8'd3, 32'h10);
        set_src(bit1(3));
        set_src('0);
        wr(A_CLR, 32'hFFFF_FFF7);
        rd(A_RAW, d); chk("R4 clear zero bits ignored", d, bit1(3));
        wr(A_CLR, bit1(3));
        rd(A_RAW, d); chk("R4 clear command", d, 32'h0);
        wr(8'd3, 32'h0);
        wr(8'd5, 32'h30);
        set_src(bit1(5));
        settle();
        rd(A_RAW, d); chk("R4 falling ignores rise", d, 32'h0);
        set_src('0);
        settle();
        rd(A_RAW, d); chk("R4 falling latched", d, bit1(5));
        wr(A_CLR, bit1(5));
        wr(8'd5, 32'h0);

        // R5: arbitration over mixed level patterns with ties
        for (int i = 0; i < N; i++) wr(8'(8'h40 + i), 32'h2000 + 32'(i));
        wr(A_EN, 32'hFFFF_FFFF);
        x = 32'h1;
        for (int p = 0; p < 20; p++) begin
            logic [31:0] pat;
            int best;
            int bp;
            for (int i = 0; i < N; i++) wr(8'(i), 32'((i * (2 * p + 1) + p) % 8));
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            pat = (p == 0) ? 32'h0 : (p == 1) ? 32'h8000_0001 : x;
            best = -1; bp = -1;
            for (int i = 0; i < N; i++) begin
                if (pat[i] && ((i * (2 * p + 1) + p) % 8) > bp) begin
                    best = i; bp = (i * (2 * p + 1) + p) % 8;
                end
            end
            set_src(pat);
            rd(A_VEC, d);
            if (best < 0) begin
                chk("R7 arbitration none pending", d, 32'hDEAD_BEEF);
            end else begin
                chk($sformatf("R5 arbitration pattern %0d", p), d, 32'h2000 + 32'(best));
                rd(A_STAT, d); chk($sformatf("R8 arbitration status %0d", p), d, 32'(best));
                settle();
                chk($sformatf("R6 no equal-level request %0d", p), 32'(nirq_n), 32'd1);
                wr(A_EOI, 32'h0);
            end
            set_src('0);
        end

        // R6/R9: climb through all eight levels, then unwind
        wr(A_DIS, 32'hFFFF_FFFF);
        for (int i = 0; i < N; i++) wr(8'(i), 32'h0);
        for (int j = 0; j < 8; j++) begin
            wr(8'(j), 32'(j));
            wr(8'(8'h40 + j), 32'h3000 + 32'(j));
        end
        wr(A_EN, 32'hFF);
        for (int j = 0; j < 8; j++) begin
            set_src(src_in | bit1(j));
            settle();
            chk($sformatf("R6 higher level requests %0d", j), 32'(nirq_n), 32'd0);
            rd(A_VEC, d); chk($sformatf("R5 nested vector %0d", j), d, 32'h3000 + 32'(j));
            rd(A_STAT, d); chk($sformatf("R8 nested status %0d", j), d, 32'(j));
            settle();
            chk($sformatf("R6 lower levels held off %0d", j), 32'(nirq_n), 32'd1);
        end
        rd(A_VEC, d);  chk("R7 full stack spurious", d, 32'hDEAD_BEEF);
        rd(A_STAT, d); chk("R8 status zero after spurious", d, 32'h0);
        for (int k = 0; k < 8; k++) begin
            wr(A_EOI, 32'hFFFF_FFFF - 32'(k));
            rd(A_STAT, d); chk($sformatf("R9 unwind status %0d", k), d, (k < 7) ? 32'(6 - k) : 32'h0);
            settle();
            chk($sformatf("R6 request after unwind %0d", k), 32'(nirq_n), 32'd0);
        end
        wr(A_EOI, 32'h0);
        rd(A_STAT, d); chk("R9 eoi on empty harmless", d, 32'h0);
        rd(A_VEC, d);  chk("R9 stack fully unwound", d, 32'h3007);
        wr(A_EOI, 32'h0);
        set_src('0);

        // R5/R6: equal priority tie
        wr(A_DIS, 32'hFFFF_FFFF);
        wr(8'd10, 32'h3);
        wr(8'd11, 32'h3);
        wr(8'h4A, 32'h400A);
        wr(8'h4B, 32'h400B);
        wr(A_EN, bit1(10) | bit1(11));
        set_src(bit1(10) | bit1(11));
        rd(A_VEC, d); chk("R5 tie goes to lower index", d, 32'h400A);
        settle();
        chk("R6 equal priority held off", 32'(nirq_n), 32'd1);
        wr(A_EOI, 32'h0);
        settle();
        chk("R6 request after eoi", 32'(nirq_n), 32'd0);
        set_src('0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule